// File: doc/BRIEF.md
# EDO DRAM byte-lane pin controller

This block is the device-side control unit of a sixteen-bit extended-data-out DRAM, written as a synthesizable model. Every system clock it samples the row strobe, the two column strobes (one per byte), the write enable, the output enable and the multiplexed address. From these it forms an internal column strobe, latches the row and column, and keeps a small word store. For each byte lane it decides whether the data pins are driven, held or released.

The model follows extended-data-out behaviour. Read data stays on the pins after the column strobe rises. A disable caused by the output enable or by the write enable stays in force until the next column strobe fall. A write attempted after the column strobe fell, while the output enable is still asserted, is refused. A cycle with the column strobe low before the row strobe falls is a refresh: the row comes from an internal counter, and that counter steps when the cycle ends. All strobes are active low. Timing windows are counted in sampled clock cycles. The lower lane is bits 7:0 and follows `casl_n`; the upper lane is bits 15:8 and follows `cash_n`.

Top module: `edo_pin_ctrl`

## Requirements
- R1: After synchronous reset `dq_oe` is 2'b00, `dq_out` is zero, `ref_busy` is 0 and `ref_row` is 0.
- R2: A lane's strobe falling while `ras_n` is low, outside refresh and with `we_n` high, loads that lane's byte of the word stored at {row, column}. The lane's `dq_oe` bit is 1 only if `oe_n` was low in the same sample.
- R3: Each byte lane follows only its own column strobe. A strobe on one lane neither drives nor writes the other lane's byte. A later fall of the second strobe within the page uses the column latched at the first fall.
- R4: Early write: `we_n` low when a lane's strobe falls stores that lane's `din` byte, and the lane stays released even if `oe_n` is low.
- R5: Late write: `we_n` falling while the lane's strobe stays low after a read start, with `oe_n` high, stores the `din` byte and releases the lane.
- R6: A late write attempted with `oe_n` low stores nothing, and the lane keeps driving the read data.
- R7: After the strobe rises with `ras_n` low, `oe_n` low and `we_n` high, the lane keeps driving unchanged data. `dq_out` changes only on a lane strobe fall.
- R8: When `ras_n` and both column strobes are high, `dq_oe` is 2'b00 one cycle later.
- R9: If `oe_n` is high when the strobe rises and stays high for `T_OEHC` samples counted from that rise, the lane is released until its next strobe fall, even after `oe_n` returns low.
- R10: If `oe_n` is low when the strobe rises and is then high for `T_OEP` consecutive samples during the strobe-high time, the lane is released until its next strobe fall. A shorter pulse does not latch the release.
- R11: `we_n` falling while the lane's strobe is high releases the lane until a strobe fall with `we_n` high.
- R12: A column strobe low before `ras_n` falls starts a refresh. `ref_busy` is 1 from the next cycle, no lane is accessed, and `ref_row` increments by one when `ras_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Lower-byte column strobe, active low |
| cash_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 16 | Write data from the pins |
| dq_out | output | 16 | Read data presented to the pins |
| dq_oe | output | 2 | Per-lane pin drive enable (bit 0 lower byte) |
| ref_busy | output | 1 | A refresh cycle is in progress |
| ref_row | output | ROW_BITS | Refresh row counter |

## Verification
Every result is due exactly one cycle after the rising edge that first samples its stimulus. This holds for drive enable, read data, release, refresh flag and counter, because each sits behind one register stage. Stored writes appear only through a later read. The bench changes inputs on the falling edge and compares outputs on the following falling edge, so each check sees the response to the vector just applied. The timing windows for the output-enable release are checked one sample short and at full length.

// File: rtl/edo_pkg.sv
// Shared definitions for the EDO pin controller.
// Assumes two byte lanes of eight bits each.
package edo_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;

    // Previous-cycle samples of the strobes used for edge detection.
    typedef struct packed {
        logic             ras;
        logic [LANES-1:0] cas;
        logic             we;
    } strobe_t;
endpackage

// File: rtl/edo_strobe_front.sv
// Strobe front end: registers last-cycle strobe levels, builds the internal
// column strobe (low while either lane strobe is low), latches row/column and
// detects refresh cycles with their row counter.
// Assumes strobes are already synchronous to clk.
module edo_strobe_front
    import edo_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic [LANES-1:0]    cas_n,
    input  logic                we_n,
    input  logic [ADDR_W-1:0]   addr,
    output strobe_t             prev,
    output logic                int_cas_n,
    output logic [ROW_BITS-1:0] row_eff,
    output logic [COL_BITS-1:0] col_eff,
    output logic                refresh_eff,
    output logic                ref_busy,
    output logic [ROW_BITS-1:0] ref_row
);
    logic                ras_fall, ras_rise, prev_int_n, int_fall, cbr;
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;

    // Edge and refresh decode from current and previous samples.
    always_comb begin
        prev_int_n  = &prev.cas;
        int_cas_n   = &cas_n;
        ras_fall    = prev.ras & ~ras_n;
        ras_rise    = ~prev.ras & ras_n;
        int_fall    = prev_int_n & ~int_cas_n;
        cbr         = ras_fall & ~prev_int_n & ~int_cas_n;
        refresh_eff = cbr | ref_busy;
        row_eff     = ras_fall ? addr[ROW_BITS-1:0] : row_q;
        col_eff     = int_fall ? addr[COL_BITS-1:0] : col_q;
    end

    // Keep last-cycle strobe levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '{ras: 1'b1, cas: '1, we: 1'b1};
        else        prev <= '{ras: ras_n, cas: cas_n, we: we_n};
    end

    // Latch row on a normal row strobe fall, column on the internal strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (ras_fall && !cbr) row_q <= addr[ROW_BITS-1:0];
            if (int_fall && !ras_n && !refresh_eff) col_q <= addr[COL_BITS-1:0];
        end
    end

    // Refresh flag and counter: set on CAS-before-RAS, step when RAS rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_busy <= 1'b0;
            ref_row  <= '0;
        end else if (cbr) begin
            ref_busy <= 1'b1;
        end else if (ras_rise && ref_busy) begin
            ref_busy <= 1'b0;
            ref_row  <= ref_row + 1'b1;
        end
    end
endmodule

// File: rtl/edo_lane_ctrl.sv
// One byte lane: decides read start, early and late write, and the drive
// state of the pins, including the release that stays latched until the next
// strobe fall. Assumes rd_data is the combinational store output at the
// current effective address.
module edo_lane_ctrl #(
    parameter int LANE_W = 8,
    parameter int T_OEHC = 2,
    parameter int T_OEP  = 3,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              p_cs,
    input  logic              ras_n,
    input  logic              int_cas_n,
    input  logic              we_n,
    input  logic              p_we,
    input  logic              oe_n,
    input  logic              refresh,
    input  logic [LANE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [LANE_W-1:0] dq_q,
    output logic              dq_oe_q
);
    localparam logic [CNT_W-1:0] LIM_HOLD  = CNT_W'(T_OEHC);
    localparam logic [CNT_W-1:0] LIM_PULSE = CNT_W'(T_OEP);

    logic             armed_q, armed_d, open_q, open_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rise_q, rise_d;
    logic             cs_fall, cs_rise, we_fall, access;
    logic             rd_start, early_wr, in_read, late_wr;
    logic             we_kill, oe_kill, idle_kill;

    // Access decode for this lane.
    always_comb begin
        cs_fall   = p_cs & ~cs_n;
        cs_rise   = ~p_cs & cs_n;
        we_fall   = p_we & ~we_n;
        access    = ~ras_n & ~refresh;
        rd_start  = cs_fall & access & we_n;
        early_wr  = cs_fall & access & ~we_n;
        in_read   = open_q & ~cs_n & ~p_cs;
        late_wr   = in_read & we_fall & oe_n;
        we_kill   = we_fall & ~(in_read & ~oe_n);
        idle_kill = ras_n & int_cas_n;
        wr_en     = early_wr | late_wr;
    end

    // Output-enable run counter during the strobe-high time.
    always_comb begin
        cnt_d  = cnt_q;
        rise_d = rise_q;
        if (!cs_n) begin
            cnt_d  = '0;
            rise_d = 1'b0;
        end else if (cs_rise) begin
            cnt_d  = oe_n ? CNT_W'(1) : '0;
            rise_d = oe_n;
        end else if (oe_n) begin
            if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d  = '0;
            rise_d = 1'b0;
        end
        oe_kill = cs_n & oe_n & (cnt_d >= (rise_d ? LIM_HOLD : LIM_PULSE));
    end

    // Next drive permission and read-in-progress flag.
    always_comb begin
        if (rd_start)                                  armed_d = 1'b1;
        else if (early_wr)                             armed_d = 1'b0;
        else if (late_wr | we_kill | oe_kill | idle_kill) armed_d = 1'b0;
        else                                           armed_d = armed_q;
        if (rd_start)               open_d = 1'b1;
        else if (cs_n || late_wr)   open_d = 1'b0;
        else                        open_d = open_q;
    end

    // Lane state registers and pin outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            open_q  <= 1'b0;
            cnt_q   <= '0;
            rise_q  <= 1'b0;
            dq_q    <= '0;
            dq_oe_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
            open_q  <= open_d;
            cnt_q   <= cnt_d;
            rise_q  <= rise_d;
            if (rd_start) dq_q <= rd_data;
            dq_oe_q <= armed_d & ~oe_n;
        end
    end
endmodule

// File: rtl/edo_word_store.sv
// Small word store with per-lane write enables and combinational read.
// Assumes one shared address for reads and writes.
module edo_word_store #(
    parameter int ADDR_BITS = 8,
    parameter int LANES     = 2,
    parameter int LANE_W    = 8
) (
    input  logic                    clk,
    input  logic [ADDR_BITS-1:0]    addr,
    input  logic [LANES-1:0]        wr_en,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_BITS;

    logic [LANES*LANE_W-1:0] mem [DEPTH];

    // Byte-lane writes.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_en[l]) mem[addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
        end
    end

    assign rd_data = mem[addr];
endmodule

// File: rtl/edo_pin_ctrl.sv
// Top of the EDO pin controller: strobe front end, word store and one lane
// controller per byte. Assumes all strobes are synchronous to clk.
module edo_pin_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int T_OEHC   = 2,
    parameter int T_OEP    = 3,
    localparam int ADDR_W  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS,
    localparam int DQ_W    = LANES * LANE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                casl_n,
    input  logic                cash_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DQ_W-1:0]     din,
    output logic [DQ_W-1:0]     dq_out,
    output logic [LANES-1:0]    dq_oe,
    output logic                ref_busy,
    output logic [ROW_BITS-1:0] ref_row
);
    localparam int T_MAX = (T_OEHC > T_OEP) ? T_OEHC : T_OEP;
    localparam int CNT_W = $clog2(T_MAX + 1) + 1;

    strobe_t             prev;
    logic                int_cas_n, refresh_eff;
    logic [ROW_BITS-1:0] row_eff;
    logic [COL_BITS-1:0] col_eff;
    logic [LANES-1:0]    cas_n, wr_en;
    logic [DQ_W-1:0]     rd_word;

    assign cas_n = {cash_n, casl_n};

    edo_strobe_front #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .ADDR_W(ADDR_W)) u_front (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .prev(prev), .int_cas_n(int_cas_n), .row_eff(row_eff),
        .col_eff(col_eff), .refresh_eff(refresh_eff), .ref_busy(ref_busy),
        .ref_row(ref_row)
    );

    edo_word_store #(.ADDR_BITS(ROW_BITS + COL_BITS), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk(clk), .addr({row_eff, col_eff}), .wr_en(wr_en), .wr_data(din),
        .rd_data(rd_word)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        edo_lane_ctrl #(.LANE_W(LANE_W), .T_OEHC(T_OEHC), .T_OEP(T_OEP), .CNT_W(CNT_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .cs_n(cas_n[g]), .p_cs(prev.cas[g]),
            .ras_n(ras_n), .int_cas_n(int_cas_n), .we_n(we_n), .p_we(prev.we),
            .oe_n(oe_n), .refresh(refresh_eff),
            .rd_data(rd_word[g*LANE_W +: LANE_W]), .wr_en(wr_en[g]),
            .dq_q(dq_out[g*LANE_W +: LANE_W]), .dq_oe_q(dq_oe[g])
        );
    end
endmodule

// File: rtl/edo_pin_ctrl_chk.sv
// Property checker for edo_pin_ctrl, attached by bind. Observes ports only.
module edo_pin_ctrl_chk #(
    parameter int ROW_BITS = 4,
    parameter int DQ_W     = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ras_n,
    input logic                casl_n,
    input logic                cash_n,
    input logic                we_n,
    input logic                oe_n,
    input logic [DQ_W-1:0]     dq_out,
    input logic [1:0]          dq_oe,
    input logic                ref_busy,
    input logic [ROW_BITS-1:0] ref_row
);
    // R2: no lane drives one cycle after oe_n is sampled high.
    assert_oe_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (dq_oe == 2'b00));

    // R4: an early write on the lower lane leaves it released.
    assert_early_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(casl_n) && !we_n && !ras_n && !ref_busy) |=> !dq_oe[0]);

    // R7: lower-lane data only changes after that lane's strobe falls.
    assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(casl_n) |=> $stable(dq_out[7:0]));

    // R7: upper-lane data only changes after that lane's strobe falls.
    assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cash_n) |=> $stable(dq_out[DQ_W-1:8]));

    // R8: all strobes high releases both lanes.
    assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && casl_n && cash_n) |=> (dq_oe == 2'b00));

    // R12: the refresh row steps by one as each refresh ends.
    assert_ref_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_busy) |-> (ref_row == ROW_BITS'($past(ref_row) + 1'b1)));
endmodule

bind edo_pin_ctrl edo_pin_ctrl_chk #(.ROW_BITS(ROW_BITS), .DQ_W(DQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
    .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .ref_busy(ref_busy), .ref_row(ref_row)
);

// File: tb/test_edo_pin_ctrl.sv
// Bench for edo_pin_ctrl: a vector table walked by one loop, then directed
// tests. Inputs change on the falling edge; outputs are compared on the next
// falling edge, one rising edge after the vector was applied.
module test_edo_pin_ctrl;
    logic        clk = 1'b0;
    logic        rst_n, ras_n, casl_n, cash_n, we_n, oe_n;
    logic [3:0]  addr;
    logic [15:0] din, dq_out;
    logic [1:0]  dq_oe;
    logic        ref_busy;
    logic [3:0]  ref_row;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #5 clk = ~clk;

    edo_pin_ctrl i_edo_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out),
        .dq_oe(dq_oe), .ref_busy(ref_busy), .ref_row(ref_row)
    );

    typedef struct packed {
        logic        ras, casl, cash, we, oe;
        logic [3:0]  a;
        logic [15:0] d;
        logic [1:0]  eo;
        logic [15:0] ed;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b1,1'b1,1'b1, 4'h0, 16'h0000, 2'b00, 16'h0000, 8'd8},  // R8 idle
        '{1'b0,1'b1,1'b1,1'b1,1'b1, 4'h3, 16'h0000, 2'b00, 16'h0000, 8'd2},  // row 3
        '{1'b0,1'b1,1'b1,1'b0,1'b1, 4'h5, 16'hA5C3, 2'b00, 16'h0000, 8'd4},  // WE low first
        '{1'b0,1'b0,1'b0,1'b0,1'b0, 4'h5, 16'hA5C3, 2'b00, 16'h0000, 8'd4},  // R4 early write, OE low
        '{1'b0,1'b1,1'b1,1'b1,1'b1, 4'h5, 16'h0000, 2'b00, 16'h0000, 8'd4},
        '{1'b1,1'b1,1'b1,1'b1,1'b1, 4'h0, 16'h0000, 2'b00, 16'h0000, 8'd8},
        '{1'b0,1'b1,1'b1,1'b1,1'b1, 4'h3, 16'h0000, 2'b00, 16'h0000, 8'd2},
        '{1'b0,1'b0,1'b0,1'b1,1'b0, 4'h5, 16'h0000, 2'b11, 16'hA5C3, 8'd2},  // R2 word read
        '{1'b0,1'b1,1'b1,1'b1,1'b0, 4'h0, 16'h0000, 2'b11, 16'hA5C3, 8'd7},  // R7 held
        '{1'b0,1'b1,1'b1,1'b1,1'b0, 4'h9, 16'h0000, 2'b11, 16'hA5C3, 8'd7},  // R7 held
        '{1'b1,1'b1,1'b1,1'b1,1'b0, 4'h0, 16'h0000, 2'b00, 16'h0000, 8'd8},  // R8 release
        '{1'b0,1'b1,1'b1,1'b1,1'b1, 4'h3, 16'h0000, 2'b00, 16'h0000, 8'd3},
        '{1'b0,1'b1,1'b1,1'b0,1'b1, 4'h5, 16'h7E00, 2'b00, 16'h0000, 8'd3},
        '{1'b0,1'b1,1'b0,1'b0,1'b1, 4'h5, 16'h7E00, 2'b00, 16'h0000, 8'd3},  // R3 upper byte write
        '{1'b0,1'b1,1'b1,1'b1,1'b1, 4'h5, 16'h0000, 2'b00, 16'h0000, 8'd3},
        '{1'b0,1'b0,1'b1,1'b1,1'b0, 4'h5, 16'h0000, 2'b01, 16'h00C3, 8'd3},  // R3 lower only
        '{1'b0,1'b0,1'b0,1'b1,1'b0, 4'hF, 16'h0000, 2'b11, 16'h7EC3, 8'd3},  // R3 latched column
        '{1'b1,1'b1,1'b1,1'b1,1'b1, 4'h0, 16'h0000, 2'b00, 16'h0000, 8'd8}
    };

    // Apply one vector and wait until its response is visible.
    task automatic step(input logic r, input logic l, input logic h, input logic w,
                        input logic o, input logic [3:0] a, input logic [15:0] d);
        ras_n = r; casl_n = l; cash_n = h; we_n = w; oe_n = o; addr = a; din = d;
        @(negedge clk);
    endtask

    // Compare drive enables, and data on driven lanes.
    task automatic pins(input string rq, input logic [1:0] eo, input logic [15:0] ed);
        logic [15:0] m;
        m = {{8{eo[1]}}, {8{eo[0]}}};
        checks++;
        if (dq_oe !== eo || (dq_out & m) !== (ed & m)) begin
            errors++;
            $display("FAIL %s: dq_oe=%b dq_out=%h expected dq_oe=%b dq_out=%h",
                     rq, dq_oe, dq_out & m, eo, ed & m);
        end
    endtask

    // Compare refresh outputs.
    task automatic refchk(input string rq, input logic b, input logic [3:0] row);
        checks++;
        if (ref_busy !== b || ref_row !== row) begin
            errors++;
            $display("FAIL %s: ref_busy=%b ref_row=%0d expected ref_busy=%b ref_row=%0d",
                     rq, ref_busy, ref_row, b, row);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ras_n = 1'b1; casl_n = 1'b1; cash_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; din = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        pins("R1", 2'b00, 16'h0000);
        checks++;
        if (dq_out !== 16'h0000) begin
            errors++;
            $display("FAIL R1: dq_out=%h expected 0000", dq_out);
        end
        refchk("R1", 1'b0, 4'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].ras, VECS[i].casl, VECS[i].cash, VECS[i].we, VECS[i].oe,
                 VECS[i].a, VECS[i].d);
            pins($sformatf("R%0d vector %0d", VECS[i].rq, i), VECS[i].eo, VECS[i].ed);
        end

        // R5 late write with OE high
        step(1,1,1,1,1, 4'h0, 16'h0);
        step(0,1,1,1,1, 4'h2, 16'h0);
        step(0,0,0,1,0, 4'h1, 16'h0);
        step(0,0,0,1,1, 4'h1, 16'h0);        pins("R5 oe high", 2'b00, 16'h0);
        step(0,0,0,0,1, 4'h1, 16'h1234);     pins("R5 late write released", 2'b00, 16'h0);
        step(0,1,1,1,1, 4'h1, 16'h0);
        step(1,1,1,1,1, 4'h0, 16'h0);
        step(0,1,1,1,1, 4'h2, 16'h0);
        step(0,0,0,1,0, 4'h1, 16'h0);        pins("R5 read back", 2'b11, 16'h1234);

        // R6 late write refused while OE low
        step(0,0,0,0,0, 4'h1, 16'hFFFF);     pins("R6 keeps driving", 2'b11, 16'h1234);
        step(0,1,1,1,1, 4'h1, 16'h0);
        step(1,1,1,1,1, 4'h0, 16'h0);
        step(0,1,1,1,1, 4'h2, 16'h0);
        step(0,0,0,1,0, 4'h1, 16'h0);        pins("R6 no write", 2'b11, 16'h1234);

        // R9 OE high at strobe rise, held
        step(0,1,1,1,1, 4'h0, 16'h0);        pins("R9 rise oe high", 2'b00, 16'h0);
        step(0,1,1,1,1, 4'h0, 16'h0);        pins("R9 hold", 2'b00, 16'h0);
        step(0,1,1,1,0, 4'h0, 16'h0);        pins("R9 stays off", 2'b00, 16'h0);

        // R10 OE pulse after strobe rise
        step(0,0,0,1,0, 4'h1, 16'h0);        pins("R10 read", 2'b11, 16'h1234);
        step(0,1,1,1,0, 4'h0, 16'h0);        pins("R10 held", 2'b11, 16'h1234);
        step(0,1,1,1,1, 4'h0, 16'h0);        pins("R10 short pulse", 2'b00, 16'h0);
        step(0,1,1,1,0, 4'h0, 16'h0);        pins("R10 short not latched", 2'b11, 16'h1234);
        step(0,1,1,1,1, 4'h0, 16'h0);
        step(0,1,1,1,1, 4'h0, 16'h0);
        step(0,1,1,1,1, 4'h0, 16'h0);        pins("R10 full pulse", 2'b00, 16'h0);
        step(0,1,1,1,0, 4'h0, 16'h0);        pins("R10 latched off", 2'b00, 16'h0);
        step(0,0,0,1,0, 4'h1, 16'h0);        pins("R10 next fall drives", 2'b11, 16'h1234);

        // R11 WE fall during strobe-high time
        step(0,1,1,1,0, 4'h0, 16'h0);        pins("R11 held", 2'b11, 16'h1234);
        step(0,1,1,0,0, 4'h0, 16'h0);        pins("R11 we fall", 2'b00, 16'h0);
        step(0,1,1,1,0, 4'h0, 16'h0);        pins("R11 stays off", 2'b00, 16'h0);
        step(0,0,0,1,0, 4'h1, 16'h0);        pins("R11 read restarts", 2'b11, 16'h1234);
        step(1,1,1,1,1, 4'h0, 16'h0);

        // R12 refresh cycles
        step(1,0,0,1,0, 4'h0, 16'h0);        pins("R12 strobe before row", 2'b00, 16'h0);
        step(0,0,0,1,0, 4'h0, 16'h0);        pins("R12 no access", 2'b00, 16'h0);
        refchk("R12 busy", 1'b1, 4'd0);
        step(1,1,1,1,1, 4'h0, 16'h0);        refchk("R12 step one", 1'b0, 4'd1);
        step(1,0,0,1,1, 4'h0, 16'h0);
        step(0,0,0,1,1, 4'h0, 16'h0);
        step(1,1,1,1,1, 4'h0, 16'h0);        refchk("R12 step two", 1'b0, 4'd2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule